// File: doc/BRIEF.md
# Variable-Length Bitstream Word Packer

This block turns a stream of variable-length codes into a gap-free bitstream delivered as fixed 64-bit words. Each input beat carries a left-aligned field of up to 144 bits and a count of how many of those bits are valid. The block joins each field to the bits still held from earlier beats. It sends out a full word whenever at least 64 bits are waiting, filling each word from its most significant bit down.

A two-entry input buffer sits between the upstream encoder and the packing register. The encoder can therefore hand over beats while the packer is still draining earlier ones. Both sides use a valid/ready handshake. Because one wide field can produce up to three output words, the packer emits at most one word per cycle and holds off new input until fewer than 64 bits remain. A beat can also carry an end-of-stream mark. Once that beat is absorbed, any partial word is topped up with 1 bits and sent, and the packer starts the next stream on a fresh word boundary.

Top module: `bit_word_packer`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: The concatenation of all emitted words, each read from bit 63 down to bit 0, equals the concatenation of the valid input bits in arrival order, each field read from its top bit down.
- R3: Bits that do not fill a whole word are kept and placed directly ahead of the next field's bits in a later word.
- R4: Only the top `in_count` bits of `in_data` (bits 143 down to 144-`in_count`) enter the stream; lower bits have no effect; counts from 0 to 144 are accepted.
- R5: The input buffer holds two beats. With `out_ready` held at 0 and an empty packer, exactly three 144-bit beats are accepted before `in_ready` stays low.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged on the next cycle.
- R7: At most one word leaves per cycle, and the packer takes a new field only when fewer than 64 bits remain after that cycle's output, so it never holds more than 207 bits.
- R8: A beat with `in_flush` = 1 causes all remaining bits to be emitted. The last partial word is padded with 1 bits in its low positions, and the next field starts at bit 63 of a new word.
- R9: A beat with `in_count` = 0 and `in_flush` = 0 is accepted and changes neither the output nor the held bits.
- R10: A flush beat that arrives when no bits are held and its own count is 0 produces no output word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input buffer can take a beat |
| in_data | input | 144 | Field, left-aligned (first bit at bit 143) |
| in_count | input | 8 | Number of valid field bits, 0 to 144 |
| in_flush | input | 1 | End-of-stream mark carried with the beat |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Downstream can take the word |
| out_data | output | 64 | Packed word, first bit at bit 63 |

## Verification
The bench compares every emitted word against a bit-queue model. It targets fields of 1, 63, 64, 65 and 144 bits, where a wrong shift offset would drop or duplicate bits at word seams. It places garbage below the count, which a design that failed to mask it would leak into later positions. It sends zero-count beats and empty flushes, which a careless design would turn into spurious or padded words. It holds the output stalled to catch a word changing under backpressure, and counts accepted beats against a blocked output to expose a buffer that is too shallow or that overruns.

// File: rtl/packer_pkg.sv
package packer_pkg;
  localparam int DEF_IN_W  = 144;
  localparam int DEF_OUT_W = 64;
  localparam int DEF_DEPTH = 2;

  // width of a counter able to hold 0..n
  function automatic int bits_for(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/pk_double_buf.sv
module pk_double_buf #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  output logic         push_ready,
  input  logic [W-1:0] push_data,
  output logic         pop_valid,
  input  logic         pop_ready,
  output logic [W-1:0] pop_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [LW-1:0] lvl;

  logic do_push, do_pop;
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop_valid && pop_ready;
  assign push_ready = (lvl != LW'(DEPTH));
  assign pop_valid  = (lvl != '0);
  assign pop_data   = slot[rp];

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) slot[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      lvl <= '0;
    end else begin
      if (do_push) wp <= wrap_inc(wp);
      if (do_pop)  rp <= wrap_inc(rp);
      case ({do_push, do_pop})
        2'b10:   lvl <= lvl + 1'b1;
        2'b01:   lvl <= lvl - 1'b1;
        default: lvl <= lvl;
      endcase
    end
  end

  AST_BUF_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= LW'(DEPTH));  // R5
  AST_BUF_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && !do_pop && lvl == LW'(DEPTH - 1)) |=> !push_ready);  // R5
endmodule

// File: rtl/pk_accum.sv
module pk_accum #(
  parameter int IN_W  = 144,
  parameter int OUT_W = 64,
  parameter int CW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_valid,
  output logic             take_ready,
  input  logic [IN_W-1:0]  take_data,
  input  logic [CW-1:0]    take_count,
  input  logic             take_flush,
  output logic             word_valid,
  input  logic             word_ready,
  output logic [OUT_W-1:0] word_data
);
  localparam int ACC_W = IN_W + OUT_W - 1;
  localparam int AW    = $clog2(ACC_W + 1);

  // keep only the top n bits of a field
  function automatic logic [IN_W-1:0] keep_top(input logic [IN_W-1:0] d,
                                                input logic [CW-1:0] n);
    logic [IN_W-1:0] m;
    m = ~({IN_W{1'b1}} >> n);
    return d & m;
  endfunction

  // fill the positions below the first n bits with ones
  function automatic logic [OUT_W-1:0] pad_ones(input logic [OUT_W-1:0] w,
                                                 input logic [AW-1:0] n);
    if (n >= AW'(OUT_W)) return w;
    return w | ({OUT_W{1'b1}} >> n);
  endfunction

  logic [ACC_W-1:0] acc, acc_base, new_bits;
  logic [AW-1:0]    lvl, lvl_base, lvl_next;
  logic             flush_pend;

  // named events for the assertions
  logic full_word, tail_word, fire, acc_take, flush_done;

  assign full_word  = (lvl >= AW'(OUT_W));
  assign tail_word  = flush_pend && (lvl != '0) && !full_word;
  assign word_valid = full_word || tail_word;
  assign word_data  = pad_ones(acc[ACC_W-1 -: OUT_W], lvl);
  assign fire       = word_valid && word_ready;

  always_comb begin
    if (!fire)          lvl_base = lvl;
    else if (full_word) lvl_base = lvl - AW'(OUT_W);
    else                lvl_base = '0;
  end

  assign take_ready = !flush_pend && (lvl_base < AW'(OUT_W));
  assign acc_take   = take_valid && take_ready;
  assign acc_base   = fire ? (acc << OUT_W) : acc;
  assign new_bits   = {keep_top(take_data, take_count), {(OUT_W-1){1'b0}}} >> lvl_base;
  assign lvl_next   = lvl_base + (acc_take ? AW'(take_count) : '0);
  assign flush_done = flush_pend && (lvl_base == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc        <= '0;
      lvl        <= '0;
      flush_pend <= 1'b0;
    end else begin
      acc <= acc_take ? (acc_base | new_bits) : acc_base;
      lvl <= lvl_next;
      if (flush_pend)    flush_pend <= !flush_done;
      else if (acc_take) flush_pend <= take_flush && (lvl_next != '0);
    end
  end

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));  // R6
  AST_ACC_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= AW'(ACC_W));  // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && tail_word) |=> (lvl == '0 && !flush_pend));  // R8
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_take && take_count == '0 && !take_flush && !fire) |=> ($stable(lvl) && $stable(acc)));  // R9
  AST_EMPTY_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_take && take_flush && lvl == '0 && take_count == '0) |=> !word_valid);  // R10
endmodule

// File: rtl/bit_word_packer.sv
module bit_word_packer #(
  parameter int IN_W  = packer_pkg::DEF_IN_W,
  parameter int OUT_W = packer_pkg::DEF_OUT_W,
  parameter int DEPTH = packer_pkg::DEF_DEPTH
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_valid,
  output logic                                in_ready,
  input  logic [IN_W-1:0]                     in_data,
  input  logic [packer_pkg::bits_for(IN_W)-1:0] in_count,
  input  logic                                in_flush,
  output logic                                out_valid,
  input  logic                                out_ready,
  output logic [OUT_W-1:0]                    out_data
);
  localparam int CW = packer_pkg::bits_for(IN_W);
  localparam int BW = IN_W + CW + 1;

  logic [BW-1:0]   buf_in, buf_out;
  logic            buf_valid, buf_ready;
  logic [IN_W-1:0] b_data;
  logic [CW-1:0]   b_count;
  logic            b_flush;

  assign buf_in = {in_flush, in_count, in_data};
  assign {b_flush, b_count, b_data} = buf_out;

  pk_double_buf #(.W(BW), .DEPTH(DEPTH)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (in_valid),
    .push_ready (in_ready),
    .push_data  (buf_in),
    .pop_valid  (buf_valid),
    .pop_ready  (buf_ready),
    .pop_data   (buf_out)
  );

  pk_accum #(.IN_W(IN_W), .OUT_W(OUT_W), .CW(CW)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_valid (buf_valid),
    .take_ready (buf_ready),
    .take_data  (b_data),
    .take_count (b_count),
    .take_flush (b_flush),
    .word_valid (out_valid),
    .word_ready (out_ready),
    .word_data  (out_data)
  );
endmodule

// File: tb/test_bit_word_packer.sv
`timescale 1ns/1ps
module test_bit_word_packer;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [143:0] in_data = '0;
  logic [7:0]   in_count = '0;
  logic         in_flush = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [63:0]  out_data;

  bit_word_packer i_bit_word_packer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_count(in_count), .in_flush(in_flush),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always #2.5 clk = ~clk;

  int    n_checks = 0, n_fail = 0;
  int    rdy_mode = 0;      // 0 always ready, 1 random, 2 blocked
  string cur_req = "R2";
  bit    q[$];
  int    pushed = 0, accepted = 0, words = 0;
  bit    held = 0;
  logic [63:0] held_data;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [143:0] rnd144();
    logic [143:0] r = '0;
    for (int k = 0; k < 5; k++) r = (r << 32) | 144'($urandom);
    return r;
  endfunction

  initial forever begin
    @(posedge clk); #1;
    out_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? 1'($urandom % 2) : 1'b0;
  end

  // reference model and output monitor
  always @(negedge clk) if (rst_n) begin
    if (in_valid && in_ready) begin
      accepted++;
      for (int i = 0; i < int'(in_count); i++) q.push_back(in_data[143-i]);
      pushed += int'(in_count);
      if (in_flush && (pushed % 64) != 0) begin
        for (int i = pushed % 64; i < 64; i++) q.push_back(1'b1);
        pushed += 64 - (pushed % 64);
      end
    end
    if (held) chk(out_valid && out_data == held_data, "R6", out_data, held_data);
    held = out_valid && !out_ready;
    held_data = out_data;
    if (out_valid && out_ready) begin
      logic [63:0] exp;
      exp = '0;
      for (int j = 0; j < 64; j++) exp[63-j] = (q.size() > 0) ? q.pop_front() : 1'bx;
      words++;
      chk(out_data === exp, cur_req, out_data, exp);
    end
  end

  task automatic send(input logic [143:0] d, input int n, input bit fl);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = d; in_count = 8'(n); in_flush = fl;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 3000 && (q.size() != 0 || out_valid); k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(q.size() == 0 && !out_valid, cur_req, 64'(q.size()), 64'd0);
  endtask

  task automatic t_reset();  // R1
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R1", 64'(in_ready), 64'd1);
  endtask

  task automatic t_basic();  // R2 R3
    cur_req = "R2/R3";
    rdy_mode = 0;
    send(rnd144(), 10, 0); send(rnd144(), 70, 0); send(rnd144(), 3, 0);
    send(rnd144(), 144, 0); send(rnd144(), 33, 0); send(rnd144(), 57, 1);
    drain();
  endtask

  task automatic t_mask();  // R4
    cur_req = "R4";
    rdy_mode = 0;
    send({144{1'b1}}, 1, 0); send(rnd144(), 63, 0); send({144{1'b1}}, 64, 0);
    send({1'b0, {143{1'b1}}}, 1, 0); send(rnd144(), 65, 0); send(rnd144(), 144, 0);
    send({144{1'b1}}, 0, 0); send(rnd144(), 8, 1);
    drain();
  endtask

  task automatic t_backpressure();  // R6 R7
    cur_req = "R6/R7";
    rdy_mode = 1;
    for (int i = 0; i < 30; i++) send(rnd144(), int'($urandom % 145), (i % 10) == 9);
    rdy_mode = 0;
    drain();
  endtask

  task automatic t_buffer();  // R5
    int a0;
    cur_req = "R5";
    rdy_mode = 2;
    repeat (3) @(posedge clk);
    a0 = accepted;
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = rnd144(); in_count = 8'd144; in_flush = 1'b0;
    repeat (20) @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    chk(accepted - a0 == 3, "R5", 64'(accepted - a0), 64'd3);
    chk(in_ready == 1'b0, "R5", 64'(in_ready), 64'd0);
    rdy_mode = 0;
    send('0, 0, 1);
    drain();
  endtask

  task automatic t_zero();  // R9 R8
    cur_req = "R9";
    rdy_mode = 0;
    send(rnd144(), 10, 0);
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0, "R9", 64'(out_valid), 64'd0);
    send({144{1'b1}}, 0, 0);
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0, "R9", 64'(out_valid), 64'd0);
    cur_req = "R8";
    send(rnd144(), 20, 1);       // 30 bits then padded word
    send(rnd144(), 64, 0);       // must start on a fresh word
    send(rnd144(), 5, 1);
    drain();
  endtask

  task automatic t_flush_empty();  // R10
    int w0;
    cur_req = "R10";
    rdy_mode = 0;
    w0 = words;
    send(rnd144(), 0, 1);
    repeat (10) @(negedge clk);
    chk(words == w0, "R10", 64'(words), 64'(w0));
    chk(out_valid == 1'b0, "R10", 64'(out_valid), 64'd0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_mask();
    t_zero();
    t_buffer();
    t_backpressure();
    t_flush_empty();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule